// File: doc/BRIEF.md
# I2C Sector-Erase Memory Slave

This block is an I2C slave in front of a small byte-wide store that keeps its data like flash. The store holds 1, 2 or 4 Kbit and is split into two equal sectors. The most significant bit of the byte address picks the sector. A master can write bytes with auto-increment, read bytes in sequence, and clear a whole sector to 0xFF. Erase is part of the bus protocol. There are two ways to ask for it, and a build parameter picks one of them.

- **Trigger mode:** each sector has one trigger byte address. A write to that address clears the sector, then programs the written byte at that address.
- **Select mode:** bit A2 of the slave address marks the transaction as an erase. The byte address that follows names the sector, and the erase starts when the master sends STOP.

The store goes busy for a set number of cycles after any program or erase. While it is busy, the slave does not acknowledge its own slave address, so the master polls with acknowledge polling until it finishes. A write-protect input blocks erases and writes. The bus pins are open-drain: each pin is an input, and SDA also has an output enable that pulls the line low.

In the 4-Kbit size, the ninth address bit is taken from slave-address bit A1, and A1 is then not compared with the strap.

Top module: `i2c_sector_mem`

## Requirements
- R1: The slave address byte has this layout: bits 7:4 = 4'b1010, bits 3:1 = A2,A1,A0, bit 0 = R/W (1 means read). In trigger mode the slave acknowledges only when A2..A0 equal `hw_addr_i`. Any other address gets NACK.
- R2: A write is the slave address, then a byte address, then data bytes. Each byte is acknowledged and stored at the current address. The address then increments and wraps from the last byte to byte 0.
- R3: A read returns bytes in sequence from the current address. The byte address can be set first by a write phase and a repeated START. The slave keeps sending bytes until the master NACKs, then releases SDA. SDA only starts being pulled low while SCL is low.
- R4: In trigger mode, a write to a sector's trigger address sets every byte of that sector to 0xFF. The data byte is then stored at the trigger address. The other sector is not changed.
- R5: The default trigger addresses are 0 for sector 0 and half the memory size for sector 1. A trigger write in sector 1 does not touch sector 0.
- R6: In select mode, A2=1 selects erase and A2=0 selects read/write. A1..A0 are compared with `hw_addr_i[1:0]`. An erase request with R/W=1 gets NACK.
- R7: In an erase-select transaction, any byte address is acknowledged. The erase clears only the sector holding that address, and it starts only on STOP. A repeated START before STOP cancels it.
- R8: While `wp_i` is high, the byte address of an erase request gets NACK and no erase follows. Data bytes of a normal write also get NACK and are not stored.
- R9: After a program the store is busy for PROG_CYC cycles. After an erase it is busy for ERASE_CYC cycles, and after a trigger erase with program for both counts added. While busy, the slave NACKs its slave address.
- R10: START and STOP are SDA falling or rising while SCL is high. A repeated START restarts the slave-address phase, and the address sent after it is the one used.
- R11: After reset SDA is released and every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| wp_i | input | 1 | Write protect, high blocks erase and writes |
| hw_addr_i | input | 3 | Strapped slave address bits A2..A0 |
| sda_oe_o | output | 1 | Pull SDA low when high |

## Verification
The assertions check these rules on every cycle:
- the slave only starts pulling SDA low while SCL is low;
- a busy store always NACKs its slave address;
- write protect stops an erase from being queued;
- STOP with a queued erase makes the store busy;
- a programmed byte lands at its address;
- the busy count goes down by one each idle cycle.

Only the bench scenarios can show:
- which bytes a trigger erase or an erase-select transaction clears;
- that a repeated START cancels a queued erase;
- address wrap at the end of memory;
- that a trigger erase with program keeps the slave busy for more polls than a plain write.

// File: rtl/i2c_sector_mem_pkg.sv
package i2c_sector_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
  } bus_state_e;

  typedef enum logic {
    MODE_TRIG = 1'b0,
    MODE_A2   = 1'b1
  } erase_mode_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_sr, sda_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end
  end

  assign scl_o      = scl_sr[1];
  assign sda_o      = sda_sr[1];
  assign scl_rise_o = scl_sr[1] & ~scl_sr[2];
  assign scl_fall_o = ~scl_sr[1] & scl_sr[2];
  // SDA edge while SCL steady high
  assign start_o    = scl_sr[1] & scl_sr[2] & ~sda_sr[1] & sda_sr[2];
  assign stop_o     = scl_sr[1] & scl_sr[2] & sda_sr[1] & ~sda_sr[2];
endmodule

// File: rtl/i2c_sector_store.sv
module i2c_sector_store #(
  parameter int unsigned BYTES     = 128,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned PROG_CYC  = 2000,
  parameter int unsigned ERASE_CYC = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic              sector_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int unsigned BUSY_MAX = PROG_CYC + ERASE_CYC;
  localparam int unsigned CNT_W    = $clog2(BUSY_MAX + 1);
  localparam int          HALF     = int'(BYTES / 2);

  logic [7:0]       mem_q [BYTES];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(BYTES); i++) mem_q[i] <= 8'hFF;
      cnt_q <= '0;
    end else begin
      for (int i = 0; i < int'(BYTES); i++)
        if (erase_i && ((i >= HALF) == sector_i)) mem_q[i] <= 8'hFF;
      if (prog_i) mem_q[addr_i] <= data_i;  // program wins over erase
      if (erase_i && prog_i)   cnt_q <= CNT_W'(BUSY_MAX);
      else if (erase_i)        cnt_q <= CNT_W'(ERASE_CYC);
      else if (prog_i)         cnt_q <= CNT_W'(PROG_CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rd_data_o = mem_q[addr_i];
  assign busy_o    = (cnt_q != '0);

  a_r9_busy_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i || erase_i) |=> busy_o);
  a_r9_busy_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !prog_i && !erase_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r2_prog_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> (mem_q[$past(addr_i)] == $past(data_i)));
endmodule

// File: rtl/i2c_sector_mem.sv
module i2c_sector_mem
  import i2c_sector_mem_pkg::*;
#(
  parameter int unsigned MEM_KBIT   = 1,
  parameter erase_mode_e ERASE_MODE = MODE_TRIG,
  parameter int unsigned TRIG_ADDR0 = 0,
  parameter int unsigned TRIG_ADDR1 = MEM_KBIT * 64,
  parameter int unsigned PROG_CYC   = 2000,
  parameter int unsigned ERASE_CYC  = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [2:0] hw_addr_i,
  output logic       sda_oe_o
);
  localparam int unsigned BYTES  = MEM_KBIT * 128;
  localparam int unsigned ADDR_W = $clog2(BYTES);
  localparam bit          WIDE   = (ADDR_W > 8);
  // strap bits compared: A2-select frees A2, wide memory borrows A1
  localparam logic [2:0] HW_MASK = (ERASE_MODE == MODE_A2) ?
                                   (WIDE ? 3'b001 : 3'b011) :
                                   (WIDE ? 3'b101 : 3'b111);
  localparam logic [ADDR_W-1:0] TRIG0 = ADDR_W'(TRIG_ADDR0);
  localparam logic [ADDR_W-1:0] TRIG1 = ADDR_W'(TRIG_ADDR1);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_bus_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(bus_start), .stop_o(bus_stop)
  );

  bus_state_e        state, ack_nxt;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg;
  logic [ADDR_W-1:0] ptr;
  logic              oe_q, er_q, er_pend, er_sec, addr_msb, mack_q;
  logic              busy, prog, erase_cmd, erase_sec, trig_hit, wr_ok;
  logic              hw_ok, sel_erase, dev_ok, byte_done;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] byte_addr;

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign hw_ok     = ((shreg[3:1] ^ hw_addr_i) & HW_MASK) == 3'b000;
  assign sel_erase = (ERASE_MODE == MODE_A2) && shreg[3];
  assign dev_ok    = (shreg[7:4] == DEV_TYPE) && hw_ok && !busy && !(sel_erase && shreg[0]);
  assign byte_addr = ADDR_W'({addr_msb, shreg});
  assign wr_ok     = !wp_i && !er_q;
  assign trig_hit  = (ERASE_MODE == MODE_TRIG) && ((ptr == TRIG0) || (ptr == TRIG1));
  assign prog      = (state == ST_WDATA) && byte_done && wr_ok;
  assign erase_cmd = (prog && trig_hit) || (bus_stop && er_pend);
  assign erase_sec = er_pend ? er_sec : ptr[ADDR_W-1];

  i2c_sector_store #(
    .BYTES(BYTES), .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_store (
    .clk_i, .rst_ni, .prog_i(prog), .erase_i(erase_cmd), .sector_i(erase_sec),
    .addr_i(ptr), .data_i(shreg), .rd_data_o(rd_data), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;  ack_nxt <= ST_IDLE;
      bit_cnt <= '0;     shreg <= '0;      ptr <= '0;
      oe_q <= 1'b0;      er_q <= 1'b0;     er_pend <= 1'b0;
      er_sec <= 1'b0;    addr_msb <= 1'b0; mack_q <= 1'b0;
    end else if (bus_start) begin
      state <= ST_DEV; bit_cnt <= '0; oe_q <= 1'b0; er_pend <= 1'b0;
    end else if (bus_stop) begin
      state <= ST_IDLE; oe_q <= 1'b0; er_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            state <= ST_IDLE;
            if (state == ST_DEV && dev_ok) begin
              oe_q <= 1'b1; state <= ST_ACK;
              er_q <= sel_erase; addr_msb <= shreg[2];
              ack_nxt <= shreg[0] ? ST_RDATA : ST_ADDR;
            end else if (state == ST_ADDR && !(er_q && wp_i)) begin
              oe_q <= 1'b1; state <= ST_ACK; ack_nxt <= ST_WDATA;
              ptr <= byte_addr;
              if (er_q) begin
                er_pend <= 1'b1; er_sec <= byte_addr[ADDR_W-1];
              end
            end else if (state == ST_WDATA && wr_ok) begin
              oe_q <= 1'b1; state <= ST_ACK; ack_nxt <= ST_WDATA;
              ptr <= ptr + 1'b1;
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          oe_q <= 1'b0; bit_cnt <= '0; state <= ack_nxt;
          if (ack_nxt == ST_RDATA) begin
            shreg <= rd_data; oe_q <= ~rd_data[7]; bit_cnt <= 4'd1; ptr <= ptr + 1'b1;
          end
        end
        ST_RDATA: if (scl_fall) begin
          if (bit_cnt == 4'd8) begin
            oe_q <= 1'b0; state <= ST_RACK;
          end else begin
            shreg <= {shreg[6:0], 1'b0}; oe_q <= ~shreg[6]; bit_cnt <= bit_cnt + 4'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              state <= ST_RDATA; shreg <= rd_data; oe_q <= ~rd_data[7];
              bit_cnt <= 4'd1; ptr <= ptr + 1'b1;
            end else state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  a_r3_pull_only_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
  a_r9_busy_nacks_dev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DEV && byte_done && busy) |=> !sda_oe_o);
  a_r8_wp_blocks_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ADDR && byte_done && er_q && wp_i) |=> (!er_pend && !sda_oe_o));
  a_r7_stop_starts_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_stop && er_pend) |=> busy);
  a_r11_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);
endmodule

// File: tb/tb_i2c_sector_mem.sv
`timescale 1ns/1ps
module tb_i2c_sector_mem;
  import i2c_sector_mem_pkg::*;

  localparam int Q = 8;  // clocks per quarter bit
  localparam logic [7:0] DEV_T  = 8'hA0;  // trigger unit, strap 000
  localparam logic [7:0] DEV_S  = 8'hA2;  // select unit, strap 001, A2=0
  localparam logic [7:0] DEV_SE = 8'hAA;  // select unit, A2=1 erase
  // {dev, byte address, data}: write, poll, read back
  localparam logic [23:0] VEC [5] = '{
    24'hA0_05_11, 24'hA0_46_22, 24'hA0_10_3C, 24'hA2_0A_33, 24'hA2_64_44
  };

  logic clk = 1'b0, rst_n = 1'b0, wp = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic oe_t, oe_s, sda_bus;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~oe_t & ~oe_s;

  i2c_sector_mem #(.ERASE_MODE(MODE_TRIG), .PROG_CYC(400), .ERASE_CYC(1000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .wp_i(wp),
    .hw_addr_i(3'b000), .sda_oe_o(oe_t));
  i2c_sector_mem #(.ERASE_MODE(MODE_A2), .PROG_CYC(400), .ERASE_CYC(1000)) dut_a2 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .wp_i(wp),
    .hw_addr_i(3'b001), .sda_oe_o(oe_s));

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask
  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(1);
    end
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); ack = ~sda_bus; wt(Q); scl_m = 1'b0; wt(1);
  endtask
  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q); b[i] = sda_bus; wt(Q); scl_m = 1'b0; wt(1);
    end
    sda_m = ~give_ack; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(1); sda_m = 1'b1;
  endtask
  task automatic xfer_write(input logic [7:0] dev, input logic [7:0] a, input logic [7:0] d,
                            output logic [2:0] acks);
    bus_start; wr_byte(dev, acks[2]); wr_byte(a, acks[1]); wr_byte(d, acks[0]); bus_stop;
  endtask
  task automatic xfer_read(input logic [7:0] dev, input logic [7:0] a,
                           output logic [7:0] d0, output logic [7:0] d1);
    logic k;
    bus_start; wr_byte(dev, k); wr_byte(a, k);
    bus_start; wr_byte(dev | 8'h01, k);
    rd_byte(1'b1, d0); rd_byte(1'b0, d1); bus_stop;
  endtask
  task automatic poll(input logic [7:0] dev, output int nacks);
    logic k;
    nacks = 0;
    forever begin
      bus_start; wr_byte(dev, k); bus_stop;
      if (k || nacks > 40) break;
      nacks++;
    end
  endtask

  initial begin
    logic [2:0] a;
    logic [7:0] d0, d1;
    logic k;
    int np, ne;
    wt(10); rst_n = 1'b1; wt(4);
    // R11 reset state
    check("R11 sda released trig", oe_t, 1'b0);
    check("R11 sda released sel", oe_s, 1'b0);
    xfer_read(DEV_T, 8'h03, d0, d1);
    check("R11 erased after reset", {d0, d1}, 16'hFFFF);

    // table walk: R2 write/readback, R1 strap match
    foreach (VEC[i]) begin
      xfer_write(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], a);
      check("R1 acks on write", a, 3'b111);
      poll(VEC[i][23:16], np);
      if (i == 0) check("R9 busy after program", np >= 1, 1'b1);
      xfer_read(VEC[i][23:16], VEC[i][15:8], d0, d1);
      check("R2 readback", d0, VEC[i][7:0]);
    end

    // R1 strap mismatch, R6 select-mode strap and erase-read
    bus_start; wr_byte(8'hAE, k); bus_stop;
    check("R1 wrong strap nack", k, 1'b0);
    bus_start; wr_byte(8'hA6, k); bus_stop;
    check("R6 A1 mismatch nack", k, 1'b0);
    bus_start; wr_byte(8'hAB, k); bus_stop;
    check("R6 erase with read nack", k, 1'b0);

    // R2 wrap, R3 sequential read across end
    bus_start; wr_byte(DEV_S, k); wr_byte(8'h7F, k);
    wr_byte(8'h5A, k); wr_byte(8'hA5, k); bus_stop;
    poll(DEV_S, np); wt(Q);
    poll(DEV_S, np);
    xfer_read(DEV_S, 8'h7F, d0, d1);
    check("R2 wrap write / R3 seq read", {d0, d1}, 16'h5AA5);
    check("R3 sda released after nack", oe_s, 1'b0);

    // R4 trigger erase of sector 0
    xfer_write(DEV_T, 8'h00, 8'h5A, a);
    poll(DEV_T, ne);
    check("R9 trigger erase busy longer", ne > 1, 1'b1);
    xfer_read(DEV_T, 8'h00, d0, d1);
    check("R4 trigger byte programmed", {d0, d1}, 16'h5AFF);
    xfer_read(DEV_T, 8'h05, d0, d1);
    check("R4 sector0 erased", d0, 8'hFF);
    xfer_read(DEV_T, 8'h46, d0, d1);
    check("R4 sector1 intact", d0, 8'h22);
    // R5 default sector-1 trigger at half size
    xfer_write(DEV_T, 8'h40, 8'hC3, a);
    poll(DEV_T, np);
    xfer_read(DEV_T, 8'h46, d0, d1);
    check("R5 sector1 erased", d0, 8'hFF);
    xfer_read(DEV_T, 8'h40, d0, d1);
    check("R5 trigger1 programmed", d0, 8'hC3);
    xfer_read(DEV_T, 8'h00, d0, d1);
    check("R5 sector0 intact", d0, 8'h5A);

    // R7 repeated START cancels queued erase
    bus_start; wr_byte(DEV_SE, k); wr_byte(8'h0A, k);
    bus_start; wr_byte(DEV_S, k); bus_stop;
    check("R7 no busy after cancel", k, 1'b1);
    xfer_read(DEV_S, 8'h0A, d0, d1);
    check("R7 cancelled erase kept data", d0, 8'h33);

    // R7 erase select on sector 1 at STOP
    bus_start; wr_byte(DEV_SE, a[2]); wr_byte(8'h5A, a[1]); bus_stop;
    check("R7 erase dev+addr ack", a[2:1], 2'b11);
    poll(DEV_S, ne);
    check("R7 busy after stop", ne >= 1, 1'b1);
    xfer_read(DEV_S, 8'h64, d0, d1);
    check("R7 sector1 erased", d0, 8'hFF);
    xfer_read(DEV_S, 8'h0A, d0, d1);
    check("R7 sector0 kept", d0, 8'h33);

    // R8 write protect
    wp = 1'b1;
    bus_start; wr_byte(DEV_SE, a[2]); wr_byte(8'h0A, a[1]); bus_stop;
    check("R8 erase addr nack", a[2:1], 2'b10);
    poll(DEV_S, np);
    check("R8 no busy after blocked erase", np, 0);
    xfer_write(DEV_S, 8'h0A, 8'h77, a);
    check("R8 data nack", a, 3'b110);
    wp = 1'b0;
    xfer_read(DEV_S, 8'h0A, d0, d1);
    check("R8 data unchanged", d0, 8'h33);

    // R10 repeated START re-opens address phase
    bus_start; wr_byte(DEV_T, k); wr_byte(8'h20, k);
    bus_start; wr_byte(DEV_T, k); wr_byte(8'h21, k); wr_byte(8'h99, k); bus_stop;
    check("R10 ack after restart", k, 1'b1);
    poll(DEV_T, np);
    xfer_read(DEV_T, 8'h20, d0, d1);
    check("R10 second address used", {d0, d1}, 16'hFF99);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R9 act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule